// File: doc/BRIEF.md
# Line-Coalescing EOI Tracker

This block follows the end-of-interrupt acknowledgements still owed for one chosen interrupt line that can go to several CPUs at once. A tracked delivery of the line loads a per-CPU destination bitmap with the CPUs that took the interrupt, and sets a pending counter to the number of those CPUs. Each CPU's EOI for the line's vector clears its own bit and lowers the counter. While the counter is above zero, the `coalesce` output tells the pin logic to drop any new assertion of the line.

A restore port brings one CPU's bit back in line with that CPU's real "EOI still outstanding" state, for example after its state has been reloaded. A synchronous clear empties the tracker. The counter and the bitmap are kept equal in population at all times. Any attempt to take the counter below zero is caught, raises an error pulse, and leaves the counter at zero.

Top module: `eoi_coalesce_tracker`

## Requirements
- R1: After `rst_n` low, or one cycle after `trk_clear` is high, `pend_cnt` is 0 and `dest_map` is all zeros. `trk_clear` overrides every other input in the same cycle.
- R2: A delivery (`dlv_valid`=1, `dlv_track`=1) while `pend_cnt` is 0 loads `dest_map` with `dlv_map` (bit i is CPU i) and sets `pend_cnt` to the number of ones in `dlv_map`. Both are visible one cycle later.
- R3: A delivery with `dlv_track`=0 leaves `dest_map` and `pend_cnt` unchanged.
- R4: A tracked delivery while `pend_cnt` is above 0 is ignored, and `err_busy` is high for exactly the following cycle.
- R5: `coalesce` is high exactly when `pend_cnt` is above 0.
- R6: An accepted EOI (`eoi_valid` and `eoi_ready`) from CPU `eoi_cpu` whose bit is set clears that bit and lowers `pend_cnt` by one.
- R7: An accepted EOI from a CPU whose bit is clear changes neither `dest_map` nor `pend_cnt`.
- R8: An accepted restore (`rs_valid`, `rs_ready`, `rs_match`=1) for CPU `rs_cpu` sets the bit and raises the count when `rs_pending`=1 and the bit is clear. It clears the bit and lowers the count when `rs_pending`=0 and the bit is set. Otherwise it changes nothing.
- R9: A restore with `rs_match`=0 changes nothing.
- R10: `eoi_ready` is low while `dlv_valid` or `trk_clear` is high, so a delivery wins over an EOI in the same cycle. `rs_ready` is also low while `eoi_valid` is high.
- R11: `pend_cnt` always equals the number of ones in `dest_map`. It never goes below 0. A decrement attempted at 0 pulses `err_uflow` and holds the counter at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| trk_clear | input | 1 | Synchronous clear of the tracker |
| dlv_valid | input | 1 | The chosen line was delivered this cycle |
| dlv_track | input | 1 | The delivery carries line-status tracking |
| dlv_map | input | N_CPU | CPUs that accepted the delivery |
| eoi_valid | input | 1 | EOI for the line's vector |
| eoi_cpu | input | IW | CPU index issuing the EOI |
| eoi_ready | output | 1 | EOI is accepted this cycle |
| rs_valid | input | 1 | Restore request |
| rs_cpu | input | IW | CPU index being restored |
| rs_match | input | 1 | CPU matches the line's destination |
| rs_pending | input | 1 | CPU still has the EOI outstanding |
| rs_ready | output | 1 | Restore is accepted this cycle |
| dest_map | output | N_CPU | Destination bitmap |
| pend_cnt | output | CW | Pending EOI count |
| coalesce | output | 1 | Drop new assertions of the line |
| err_busy | output | 1 | Tracked delivery arrived while busy (one-cycle pulse) |
| err_uflow | output | 1 | Decrement attempted at zero (one-cycle pulse) |

## Verification
Every state result (`dest_map`, `pend_cnt`, `coalesce`, and the two error pulses) comes from a register. It is therefore due exactly one clock edge after the cycle that carries the stimulus. The handshake outputs `eoi_ready` and `rs_ready` are combinational and are due in the same cycle. The bench drives inputs on the falling edge and samples the ready outputs before the next rising edge. It samples the registered results on the falling edge that follows that rising edge, so each check lands one edge after its stimulus.

// File: rtl/eoi_coalesce_tracker.sv
module eoi_coalesce_tracker #(
  parameter int N_CPU = 16,
  parameter int IW    = $clog2(N_CPU),
  parameter int CW    = $clog2(N_CPU + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             trk_clear,
  input  logic             dlv_valid,
  input  logic             dlv_track,
  input  logic [N_CPU-1:0] dlv_map,
  input  logic             eoi_valid,
  input  logic [IW-1:0]    eoi_cpu,
  output logic             eoi_ready,
  input  logic             rs_valid,
  input  logic [IW-1:0]    rs_cpu,
  input  logic             rs_match,
  input  logic             rs_pending,
  output logic             rs_ready,
  output logic [N_CPU-1:0] dest_map,
  output logic [CW-1:0]    pend_cnt,
  output logic             coalesce,
  output logic             err_busy,
  output logic             err_uflow
);

  logic [CW-1:0]    dlv_pop;
  logic [N_CPU-1:0] map_nx;
  logic [CW-1:0]    cnt_nx;
  logic             busy_nx, uflow_nx;
  logic             eoi_fire, rs_fire, eoi_hit, rs_cur;

  assign eoi_ready = !trk_clear && !dlv_valid;
  assign rs_ready  = eoi_ready && !eoi_valid;
  assign eoi_fire  = eoi_valid && eoi_ready;
  assign rs_fire   = rs_valid && rs_ready && rs_match;
  assign eoi_hit   = dest_map[eoi_cpu];
  assign rs_cur    = dest_map[rs_cpu];
  assign coalesce  = (pend_cnt != '0);

  always_comb begin
    dlv_pop = '0;
    for (int i = 0; i < N_CPU; i++)
      dlv_pop = dlv_pop + {{(CW-1){1'b0}}, dlv_map[i]};
  end

  always_comb begin
    map_nx   = dest_map;
    cnt_nx   = pend_cnt;
    busy_nx  = 1'b0;
    uflow_nx = 1'b0;
    if (trk_clear) begin
      map_nx = '0;
      cnt_nx = '0;
    end else if (dlv_valid) begin
      if (dlv_track) begin
        if (pend_cnt == '0) begin
          map_nx = dlv_map;
          cnt_nx = dlv_pop;
        end else begin
          busy_nx = 1'b1;
        end
      end
    end else if (eoi_fire) begin
      if (eoi_hit) begin
        map_nx[eoi_cpu] = 1'b0;
        if (pend_cnt == '0) uflow_nx = 1'b1;
        else cnt_nx = pend_cnt - 1'b1;
      end
    end else if (rs_fire && (rs_cur != rs_pending)) begin
      map_nx[rs_cpu] = rs_pending;
      if (rs_pending) begin
        if (pend_cnt != CW'(N_CPU)) cnt_nx = pend_cnt + 1'b1;
      end else if (pend_cnt == '0) begin
        uflow_nx = 1'b1;
      end else begin
        cnt_nx = pend_cnt - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dest_map  <= '0;
      pend_cnt  <= '0;
      err_busy  <= 1'b0;
      err_uflow <= 1'b0;
    end else begin
      dest_map  <= map_nx;
      pend_cnt  <= cnt_nx;
      err_busy  <= busy_nx;
      err_uflow <= uflow_nx;
    end
  end

endmodule

// File: rtl/eoi_coalesce_tracker_chk.sv
module eoi_coalesce_tracker_chk #(
  parameter int N_CPU = 16,
  parameter int IW    = $clog2(N_CPU),
  parameter int CW    = $clog2(N_CPU + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             trk_clear,
  input logic             dlv_valid,
  input logic             dlv_track,
  input logic [N_CPU-1:0] dlv_map,
  input logic             eoi_valid,
  input logic [IW-1:0]    eoi_cpu,
  input logic             eoi_ready,
  input logic             rs_valid,
  input logic             rs_match,
  input logic             rs_ready,
  input logic [N_CPU-1:0] dest_map,
  input logic [CW-1:0]    pend_cnt,
  input logic             coalesce,
  input logic             err_busy,
  input logic             err_uflow
);

  assert_clear_empties_R1: assert property (@(posedge clk) disable iff (!rst_n)
    trk_clear |=> (pend_cnt == '0 && dest_map == '0));

  assert_delivery_loads_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (dlv_valid && dlv_track && !trk_clear && pend_cnt == '0) |=> dest_map == $past(dlv_map));

  assert_busy_ignored_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (dlv_valid && dlv_track && !trk_clear && pend_cnt != '0) |=> (err_busy && $stable(dest_map)));

  assert_coalesce_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
    coalesce == ($countones(dest_map) != 0));

  assert_stray_eoi_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi_valid && eoi_ready && !dest_map[eoi_cpu]) |=> ($stable(dest_map) && $stable(pend_cnt)));

  assert_no_match_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rs_valid && !rs_match && !trk_clear && !dlv_valid && !eoi_valid) |=> $stable(dest_map));

  assert_priority_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (dlv_valid || trk_clear) |-> (!eoi_ready && !rs_ready));

  assert_rs_blocked_R10: assert property (@(posedge clk) disable iff (!rst_n)
    eoi_valid |-> !rs_ready);

  assert_count_match_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(dest_map) == int'(pend_cnt));

  assert_no_underflow_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !err_uflow);

endmodule

bind eoi_coalesce_tracker eoi_coalesce_tracker_chk #(.N_CPU(N_CPU), .IW(IW), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .trk_clear(trk_clear), .dlv_valid(dlv_valid),
  .dlv_track(dlv_track), .dlv_map(dlv_map), .eoi_valid(eoi_valid), .eoi_cpu(eoi_cpu),
  .eoi_ready(eoi_ready), .rs_valid(rs_valid), .rs_match(rs_match), .rs_ready(rs_ready),
  .dest_map(dest_map), .pend_cnt(pend_cnt), .coalesce(coalesce),
  .err_busy(err_busy), .err_uflow(err_uflow)
);

// File: tb/test_eoi_coalesce_tracker.sv
`timescale 1ns/1ps
module test_eoi_coalesce_tracker;
  localparam int N = 16;
  localparam int IW = 4;
  localparam int CW = 5;

  logic clk = 1'b0, rst_n = 1'b0;
  logic trk_clear = 0, dlv_valid = 0, dlv_track = 0;
  logic [N-1:0] dlv_map = '0;
  logic eoi_valid = 0; logic [IW-1:0] eoi_cpu = '0;
  logic rs_valid = 0, rs_match = 0, rs_pending = 0; logic [IW-1:0] rs_cpu = '0;
  logic eoi_ready, rs_ready, coalesce, err_busy, err_uflow;
  logic [N-1:0] dest_map; logic [CW-1:0] pend_cnt;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  eoi_coalesce_tracker #(.N_CPU(N)) i_eoi_coalesce_tracker (
    .clk(clk), .rst_n(rst_n), .trk_clear(trk_clear), .dlv_valid(dlv_valid),
    .dlv_track(dlv_track), .dlv_map(dlv_map), .eoi_valid(eoi_valid), .eoi_cpu(eoi_cpu),
    .eoi_ready(eoi_ready), .rs_valid(rs_valid), .rs_cpu(rs_cpu), .rs_match(rs_match),
    .rs_pending(rs_pending), .rs_ready(rs_ready), .dest_map(dest_map), .pend_cnt(pend_cnt),
    .coalesce(coalesce), .err_busy(err_busy), .err_uflow(err_uflow));

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  function automatic int pop(input logic [N-1:0] v);
    int c = 0;
    for (int i = 0; i < N; i++) c += int'(v[i]);
    return c;
  endfunction

  task automatic idle();
    trk_clear = 0; dlv_valid = 0; dlv_track = 0; eoi_valid = 0; rs_valid = 0;
  endtask

  task automatic step();
    @(posedge clk); @(negedge clk);
    idle();
  endtask

  task automatic state(input string tag, input logic [N-1:0] m);
    chk({tag, " map"}, 32'(dest_map), 32'(m));
    chk({tag, " cnt R11"}, 32'(pend_cnt), 32'(pop(m)));
    chk({tag, " coalesce R5"}, 32'(coalesce), 32'(m != '0));
    chk({tag, " uflow R11"}, 32'(err_uflow), 0);
  endtask

  task automatic deliver(input logic trk, input logic [N-1:0] m);
    dlv_valid = 1; dlv_track = trk; dlv_map = m; step();
  endtask

  task automatic eoi(input int cpu);
    eoi_valid = 1; eoi_cpu = IW'(cpu);
    #1 chk("eoi_ready R10", 32'(eoi_ready), 1);
    step();
  endtask

  task automatic restore(input int cpu, input logic mt, input logic pend);
    rs_valid = 1; rs_cpu = IW'(cpu); rs_match = mt; rs_pending = pend;
    #1 chk("rs_ready R10", 32'(rs_ready), 1);
    step();
  endtask

  task automatic t_reset();
    state("R1 reset", '0);
  endtask

  task automatic t_deliver_and_drain();
    deliver(1, 16'hA5A0);
    state("R2 load", 16'hA5A0);
    eoi(5); state("R6 eoi set bit", 16'hA580);
    eoi(0); state("R7 eoi clear bit", 16'hA580);
    eoi(7); eoi(8); eoi(10); eoi(13);
    state("R6 drained", 16'h8000);
    eoi(15); state("R6 empty", '0);
  endtask

  task automatic t_untracked();
    deliver(0, 16'hFFFF); state("R3 untracked", '0);
  endtask

  task automatic t_busy();
    deliver(1, 16'h0003);
    deliver(1, 16'hFF00);
    chk("R4 err_busy", 32'(err_busy), 1);
    state("R4 ignored", 16'h0003);
    step();
    chk("R4 pulse ends", 32'(err_busy), 0);
  endtask

  task automatic t_priority();
    dlv_valid = 1; dlv_track = 0; eoi_valid = 1; eoi_cpu = 0; rs_valid = 1;
    #1 chk("R10 eoi_ready low", 32'(eoi_ready), 0);
    chk("R10 rs_ready low", 32'(rs_ready), 0);
    step();
    state("R10 eoi held off", 16'h0003);
    eoi_valid = 1; eoi_cpu = 1; rs_valid = 1; rs_match = 1; rs_cpu = 0; rs_pending = 0;
    #1 chk("R10 rs blocked by eoi", 32'(rs_ready), 0);
    step();
    state("R10 only eoi", 16'h0001);
  endtask

  task automatic t_restore();
    restore(9, 1, 1);  state("R8 restore set", 16'h0201);
    restore(9, 1, 1);  state("R8 restore equal", 16'h0201);
    restore(0, 1, 0);  state("R8 restore clear", 16'h0200);
    restore(4, 0, 1);  state("R9 no match", 16'h0200);
    restore(9, 0, 0);  state("R9 no match clr", 16'h0200);
  endtask

  task automatic t_clear();
    trk_clear = 1; dlv_valid = 1; dlv_track = 1; dlv_map = 16'h00FF;
    #1 chk("R10 clear blocks eoi", 32'(eoi_ready), 0);
    step();
    state("R1 clear wins", '0);
  endtask

  task automatic t_full_and_zero();
    deliver(1, '1); state("R2 all cpus", '1);
    trk_clear = 1; step();
    deliver(1, '0); state("R2 empty map", '0);
    chk("R4 no busy at zero", 32'(err_busy), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_deliver_and_drain();
    t_untracked();
    t_busy();
    t_priority();
    t_restore();
    t_clear();
    t_full_and_zero();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got hang expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule